// File: doc/BRIEF.md
# Quad SPI Execute-in-Place Read Controller

This block sits on the host side of a serial NOR flash and fetches bytes over a four-bit SPI bus using the quad I/O fast read command. A requester hands it a 24-bit start address and a byte count over a valid/ready handshake. The controller lowers chip select and runs the transaction phases: the command byte, the address, the mode byte, the dummy clocks and the data. It returns each received byte as a one-cycle pulse on a streaming output.

The flash can be left in continuous read mode, so that the next transaction starts directly with the address. The controller records whether it last armed that mode. When it is armed, the controller leaves out the 8-clock command phase on the next request. A configuration input, sampled when a request is accepted, chooses whether the mode byte keeps the flash in that state or takes it out.

The serial clock runs at half the system clock and idles low. Each serial bit spans two system cycles: one with the clock low, in which outputs change, and one with the clock high, in which the controller samples the input lines.

Top module: `qxip_rd`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io_oe is 0000, dout_valid is 0, and no request is accepted until the chip-select gap has elapsed.
- R2: While qe_ok is 0, req_ready stays 0 and cs_n stays high, whatever req_valid does.
- R3: When continuous mode is not armed, the transaction begins with the code 0xEB on io_out[0], MSB first, one bit per sck rising edge for 8 edges, with io_oe = 0001.
- R4: The 24-bit address follows on all four lines, io_out[3] carrying the most significant bit of each nibble, A23..A20 first, over 6 rising edges with io_oe = 1111.
- R5: Two more rising edges carry the mode byte, high nibble first. It is 0xA0 if cont_keep was 1 at acceptance, and 0x00 otherwise.
- R6: Exactly 4 dummy rising edges follow the mode byte. io_oe is 0000 from the first dummy clock until the end of the transaction, so the lines are released before the first data-out falling edge.
- R7: After a transaction that sent mode 0xA0, the next transaction has no command phase and starts with the address. A transaction then takes 12 + 2N rising edges in place of 20 + 2N, where N is the byte count.
- R8: io_in is sampled on each sck rising edge in the data phase, high nibble first. Each assembled byte appears on dout_data with a one-cycle dout_valid pulse. The bytes come from consecutive addresses, wrapping at 24 bits, and N = req_len_m1 + 1.
- R9: Between transactions, cs_n stays high for at least CSH_MIN system cycles.
- R10: sck is low whenever cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qe_ok | input | 1 | Quad mode is enabled in the flash; requests are refused while low |
| cont_keep | input | 1 | 1: send mode 0xA0 (stay continuous); 0: send 0x00 |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 24 | Start byte address |
| req_len_m1 | input | LEN_W | Byte count minus one |
| dout_valid | output | 1 | One-cycle strobe for each received byte |
| dout_data | output | 8 | Received byte |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idle low |
| io_out | output | 4 | Values driven onto the IO lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Values read from the IO lines |

## Verification
On every cycle, the embedded assertions check that the serial clock stays low while chip select is high. They also check the chip-select high time, that chip select only falls while quad mode is enabled, and the output enables during the command, address and data phases. They check that byte strobes last a single cycle. Only the bench scenarios can show the serial content, that is the 0xEB code, the address nibbles and the mode byte. The same holds for the command phase being dropped after an armed transaction and its return once the controller has sent 0x00. Data values and their address wrap at the top of the 24-bit space are checked against a flash model through a byte scoreboard.

// File: rtl/qxip_rd.sv
module qxip_rd #(
  parameter int LEN_W   = 8,
  parameter int CSH_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qe_ok,
  input  logic             cont_keep,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len_m1,
  output logic             dout_valid,
  output logic [7:0]       dout_data,
  output logic             cs_n,
  output logic             sck,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);

  localparam int        CSH_W    = $clog2(CSH_MIN + 1);
  localparam logic [7:0] RD_CODE = 8'hEB;
  localparam logic [3:0] KEEP_NIB = 4'hA;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_MODE, S_DUMMY, S_DATA, S_END} st_t;

  st_t              state;
  logic [2:0]       cnt;
  logic             ph;
  logic [23:0]      addr_sr;
  logic [LEN_W-1:0] left;
  logic             stay_q;
  logic             cont_armed;
  logic [3:0]       hi_nib;
  logic [CSH_W-1:0] gap;
  logic [2:0]       last;

  assign req_ready = (state == S_IDLE) && (gap == '0) && qe_ok;

  always_comb begin
    case (state)
      S_CMD:   last = 3'd7;
      S_ADDR:  last = 3'd5;
      S_MODE:  last = 3'd1;
      S_DUMMY: last = 3'd3;
      default: last = 3'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      ph         <= 1'b0;
      addr_sr    <= '0;
      left       <= '0;
      stay_q     <= 1'b0;
      cont_armed <= 1'b0;
      hi_nib     <= '0;
      gap        <= CSH_W'(CSH_MIN - 1);
      cs_n       <= 1'b1;
      sck        <= 1'b0;
      io_out     <= '0;
      io_oe      <= '0;
      dout_valid <= 1'b0;
      dout_data  <= '0;
    end else begin
      dout_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (gap != '0) gap <= gap - 1'b1;
          if (req_valid && req_ready) begin
            cs_n    <= 1'b0;
            addr_sr <= req_addr;
            left    <= req_len_m1;
            stay_q  <= cont_keep;
            cnt     <= '0;
            ph      <= 1'b0;
            state   <= cont_armed ? S_ADDR : S_CMD;
          end
        end
        S_END: begin
          cs_n   <= 1'b1;
          sck    <= 1'b0;
          io_oe  <= '0;
          io_out <= '0;
          gap    <= CSH_W'(CSH_MIN - 1);
          state  <= S_IDLE;
        end
        default: begin
          ph <= ~ph;
          if (!ph) begin
            sck <= 1'b0;
            case (state)
              S_CMD: begin
                io_oe  <= 4'b0001;
                io_out <= {3'b000, RD_CODE[3'd7 - cnt]};
              end
              S_ADDR: begin
                io_oe   <= 4'hF;
                io_out  <= addr_sr[23:20];
                addr_sr <= {addr_sr[19:0], 4'h0};
              end
              S_MODE: begin
                io_oe  <= 4'hF;
                io_out <= (cnt == 3'd0 && stay_q) ? KEEP_NIB : 4'h0;
              end
              default: begin
                io_oe  <= 4'h0;
                io_out <= 4'h0;
              end
            endcase
          end else begin
            sck <= 1'b1;
            if (state == S_DATA) begin
              if (!cnt[0]) hi_nib <= io_in;
              else begin
                dout_data  <= {hi_nib, io_in};
                dout_valid <= 1'b1;
              end
            end
            if (cnt != last) cnt <= cnt + 1'b1;
            else begin
              cnt <= '0;
              case (state)
                S_CMD:   state <= S_ADDR;
                S_ADDR:  state <= S_MODE;
                S_MODE: begin
                  state      <= S_DUMMY;
                  cont_armed <= stay_q;
                end
                S_DUMMY: state <= S_DATA;
                default: begin
                  if (left == '0) state <= S_END;
                  else left <= left - 1'b1;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  logic [CSH_W-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != CSH_W'(CSH_MIN)) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r9_cs_high_time: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) |-> (hi_cnt >= CSH_W'(CSH_MIN)));

  a_r2_start_needs_qe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(qe_ok));

  a_r3_cmd_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CMD && ph) |-> (io_oe == 4'b0001));

  a_r4_addr_four_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && ph) |-> (io_oe == 4'hF));

  a_r6_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (io_oe == 4'h0));

  a_r8_byte_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid);

endmodule

// File: tb/tb_qxip_rd.sv
module tb_qxip_rd;
  localparam int LEN_W = 8;
  localparam int CSH_MIN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic qe_ok = 1'b0, cont_keep = 1'b0, req_valid = 1'b0;
  logic req_ready;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len_m1 = '0;
  logic dout_valid;
  logic [7:0] dout_data;
  logic cs_n, sck;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = '0;

  always #5 clk = ~clk;

  qxip_rd #(.LEN_W(LEN_W), .CSH_MIN(CSH_MIN)) dut (
    .clk(clk), .rst_n(rst_n), .qe_ok(qe_ok), .cont_keep(cont_keep),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .dout_valid(dout_valid), .dout_data(dout_data),
    .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  int checks = 0, errors = 0;
  logic [7:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fdat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // flash model
  bit m_cont = 0, m_active = 0, m_skip = 0, m_done = 0, m_oe_bad = 0;
  int m_rise = 0;
  logic [7:0] m_cmd, m_mode;
  logic [23:0] m_addr;

  always @(negedge cs_n) begin
    m_active = 1; m_rise = 0; m_skip = m_cont;
    m_cmd = '0; m_mode = '0; m_addr = '0; m_oe_bad = 0;
  end

  always @(posedge sck) if (!cs_n && m_active) begin
    int p;
    p = m_skip ? m_rise + 8 : m_rise;
    if (p < 8) begin
      m_cmd = {m_cmd[6:0], io_out[0]};
      if (io_oe != 4'b0001) m_oe_bad = 1;
    end else if (p < 14) begin
      m_addr = {m_addr[19:0], io_out};
      if (io_oe != 4'hF) m_oe_bad = 1;
    end else if (p < 16) begin
      m_mode = {m_mode[3:0], io_out};
      if (io_oe != 4'hF) m_oe_bad = 1;
    end
    m_rise++;
  end

  always @(negedge sck) if (!cs_n && m_active) begin
    int hdr, k;
    logic [7:0] b;
    hdr = m_skip ? 12 : 20;
    if (m_rise >= hdr) begin
      k = m_rise - hdr;
      if (io_oe != 4'h0) m_oe_bad = 1;
      b = fdat(24'(m_addr + 24'(k / 2)));
      io_in <= (k % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  always @(posedge cs_n) if (m_active) begin
    m_active = 0;
    m_cont = (m_mode[7:4] == 4'hA);
    m_done = 1;
  end

  // chip-select gap monitor
  int hi_run = 0, last_gap = 0;
  always @(posedge clk) if (rst_n) begin
    if (cs_n) hi_run++;
    else if (hi_run > 0) begin last_gap = hi_run; hi_run = 0; end
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && dout_valid) begin
    if (expq.size() == 0) chk(0, "R8", "unexpected byte", dout_data, 0);
    else begin
      logic [7:0] e;
      e = expq.pop_front();
      chk(dout_data == e, "R8", "data byte", dout_data, e);
    end
  end

  task automatic xfer(input logic [23:0] a, input int n, input bit keep, input bit exp_skip);
    int exp_rise;
    m_done = 0;
    @(negedge clk);
    req_addr = a; req_len_m1 = LEN_W'(n - 1); cont_keep = keep; req_valid = 1'b1;
    do @(posedge clk); while (!req_ready);
    for (int i = 0; i < n; i++) expq.push_back(fdat(24'(a + 24'(i))));
    @(negedge clk);
    req_valid = 1'b0;
    wait (m_done);
    @(negedge clk);
    exp_rise = (exp_skip ? 12 : 20) + 2 * n;
    chk(m_skip == exp_skip, "R7", "command phase skipped", m_skip, exp_skip);
    chk(m_rise == exp_rise, "R6", "rising edges (R7 count)", m_rise, exp_rise);
    if (!exp_skip) chk(m_cmd == 8'hEB, "R3", "command code", m_cmd, 8'hEB);
    chk(m_addr == a, "R4", "address", m_addr, a);
    chk(m_mode == (keep ? 8'hA0 : 8'h00), "R5", "mode byte", m_mode, keep ? 8'hA0 : 8'h00);
    chk(!m_oe_bad, "R6", "output enables per phase (R3 R4)", m_oe_bad, 0);
    chk(last_gap >= CSH_MIN, "R9", "cs_n high cycles", last_gap, CSH_MIN);
    chk(expq.size() == 0, "R8", "bytes outstanding", expq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1, "R1", "cs_n after reset", cs_n, 1);
    chk(sck === 1'b0, "R10", "sck after reset (R1)", sck, 0);
    chk(io_oe === 4'h0, "R1", "io_oe after reset", io_oe, 0);
    chk(dout_valid === 1'b0, "R1", "dout_valid after reset", dout_valid, 0);

    req_valid = 1'b1;
    begin
      bit bad;
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (req_ready !== 1'b0 || cs_n !== 1'b1) bad = 1;
      end
      chk(!bad, "R2", "refused while qe_ok low", bad, 0);
    end
    req_valid = 1'b0;
    qe_ok = 1'b1;

    xfer(24'h123456, 4, 1, 0);
    xfer(24'hABCDEF, 1, 1, 1);
    xfer(24'hFFFFFE, 3, 0, 1);
    xfer(24'h000100, 2, 0, 0);
    xfer(24'h00FF00, 5, 1, 0);
    xfer(24'h7FFFFF, 2, 1, 1);

    repeat (10) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R10", "idle lines", {cs_n, sck}, 2'b10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule